// File: doc/BRIEF.md
# Sixteen-bit Compare/Capture Timer

This block is a 16-bit up-counter that advances once per timer-clock enable pulse. Two compare channels watch it, and one capture channel can take a snapshot of it. Four event flags record counter rollover, a compare hit on channel A, a compare hit on channel B and a capture. Each flag has a mask bit. An interrupt line for a flag is raised only while that flag is set, its mask bit is one and the global enable is one. Software clears a flag by writing a one to its bit, or the interrupt controller clears it by acknowledging the line.

The counting mode is picked by `mode_sel`:
- `2'b00`: free-running. The counter wraps from 0xFFFF to zero.
- `2'b01`: the counter restarts from zero after reaching the channel-A compare value.
- `2'b10`: the counter restarts from zero after reaching the capture register, which then serves as the period register.
- `2'b11`: behaves as free-running.

Force strobes produce a compare-output pulse without touching the flags or the count. A software load of the counter masks compare hits for the next timer tick. All control pins are plain level or strobe inputs. There is no streaming interface and so no back-pressure. Every strobe is sampled on the clock edge where it is high.

Top module: `cc_timer16`

## Requirements
- R1: After reset the count, both compare registers, the capture register, the mask and all four flags are zero, and the match pulses and interrupt lines are low.
- R2: On each clock with `tick_en` high and `cnt_wr` low, the count increases by one. Without `tick_en` it holds. A `cnt_wr` loads `cnt_wdata` and takes priority over a tick.
- R3: The rollover flag (bit 0 of `flags_o`) is set on the edge where a tick advances the counter from 0xFFFF. In free-running mode the count then reads zero.
- R4: In mode `2'b01`, a tick taken while the count equals the channel-A compare value loads zero into the counter instead of incrementing it.
- R5: A tick taken while the count equals a compare register sets that channel's flag (bit 1 for A, bit 2 for B) on that edge. The flag is therefore visible one timer clock after the matching count. The same edge raises `match_a_o` or `match_b_o` for one cycle.
- R6: Compare hits on both channels are suppressed on the first tick at or after a `cnt_wr`, including a tick in the same cycle as the write.
- R7: `force_a` or `force_b` raises the matching pulse output on the next edge. It does not set a flag and does not restart or alter the count.
- R8: In modes other than `2'b10`, `cap_evt` copies the current count into the capture register and sets the capture flag (bit 3). A capture event wins over a simultaneous `cap_wr`.
- R9: In mode `2'b10`, the counter restarts from zero on a tick at a count equal to the capture register, and that tick sets the capture flag. `cap_evt` is ignored in this mode.
- R10: A one in `flag_clr` or `irq_ack` clears the flag at that bit position. Zero bits have no effect.
- R11: When a flag is set by hardware and cleared in the same cycle, the flag ends up set.
- R12: `irq_o[i]` is high exactly when flag i is set, mask bit i is one and `gie` is one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Timer-clock enable; counter advances when high |
| mode_sel | input | 2 | Counting mode (00 free, 01 top=A, 10 top=capture, 11 free) |
| cnt_wr | input | 1 | Load strobe for the counter |
| cnt_wdata | input | 16 | Counter load value |
| cmpa_wr | input | 1 | Write strobe for compare register A |
| cmpa_wdata | input | 16 | Compare register A write value |
| cmpb_wr | input | 1 | Write strobe for compare register B |
| cmpb_wdata | input | 16 | Compare register B write value |
| cap_wr | input | 1 | Write strobe for the capture register |
| cap_wdata | input | 16 | Capture register write value |
| cap_evt | input | 1 | Capture event strobe |
| force_a | input | 1 | Forced compare strobe, channel A |
| force_b | input | 1 | Forced compare strobe, channel B |
| mask_wr | input | 1 | Write strobe for the mask bits |
| mask_wdata | input | 4 | Mask bits (0 rollover, 1 A, 2 B, 3 capture) |
| flag_clr | input | 4 | Write-one-to-clear flag strobes |
| gie | input | 1 | Global interrupt enable |
| irq_ack | input | 4 | Per-line interrupt acknowledge |
| cnt_o | output | 16 | Current count |
| cap_o | output | 16 | Capture register |
| flags_o | output | 4 | Event flags |
| irq_o | output | 4 | Masked interrupt requests |
| match_a_o | output | 1 | One-cycle compare/force pulse, channel A |
| match_b_o | output | 1 | One-cycle compare/force pulse, channel B |

## Verification
Two functions can land in the same cycle and need explicit coverage. The first pair is a hardware flag set and a software clear of that flag. The bench provokes it by issuing a rollover clear on the edge where 0xFFFF rolls over, and expects the flag to stay set. The second pair is a counter load and a compare hit. The bench reloads the counter with exactly the channel-A compare value and then ticks, and expects no flag and no pulse. A behavioural reference model, stepped on every clock, also judges randomized traffic in which loads, captures, clears and ticks collide freely.

// File: rtl/cc_timer_pkg.sv
package cc_timer_pkg;
  typedef enum logic [1:0] {
    MODE_FREE    = 2'b00,
    MODE_TOP_A   = 2'b01,
    MODE_TOP_CAP = 2'b10,
    MODE_SPARE   = 2'b11
  } tmode_e;

  localparam int FLG_ROLL = 0;
  localparam int FLG_CMPA = 1;
  localparam int FLG_CMPB = 2;
  localparam int FLG_CAP  = 3;
  localparam int NUM_FLG  = 4;
  localparam int NUM_CMP  = 2;
endpackage

// File: rtl/cc_timer_count.sv
module cc_timer_count
  import cc_timer_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  tmode_e       mode,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] top_a,
  input  logic [W-1:0] top_cap,
  output logic [W-1:0] cnt,
  output logic         cmp_en,
  output logic         roll_evt,
  output logic         top_evt
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic         blk;
  logic         advance;
  logic         use_top;
  logic [W-1:0] top_sel;

  always_comb begin
    use_top = 1'b0;
    top_sel = '0;
    case (mode)
      MODE_TOP_A:   begin use_top = 1'b1; top_sel = top_a;   end
      MODE_TOP_CAP: begin use_top = 1'b1; top_sel = top_cap; end
      default:      begin use_top = 1'b0; top_sel = '0;      end
    endcase
  end

  assign advance  = tick & ~wr;
  assign top_evt  = advance & use_top & (cnt == top_sel);
  assign roll_evt = advance & (cnt == MAXV);
  assign cmp_en   = advance & ~blk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      blk <= 1'b0;
    end else begin
      if (wr)           cnt <= wdata;
      else if (advance) cnt <= top_evt ? '0 : cnt + 1'b1;
      if (wr)           blk <= 1'b1;
      else if (tick)    blk <= 1'b0;
    end
  end
endmodule

// File: rtl/cc_timer_cmp.sv
module cc_timer_cmp #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmp_en,
  input  logic [W-1:0] cnt,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         force_i,
  output logic [W-1:0] val,
  output logic         hit,
  output logic         pulse
);
  assign hit = cmp_en & (cnt == val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val   <= '0;
      pulse <= 1'b0;
    end else begin
      if (wr) val <= wdata;
      pulse <= hit | force_i;
    end
  end
endmodule

// File: rtl/cc_timer_irq.sv
module cc_timer_irq #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] ack,
  input  logic         mask_wr,
  input  logic [N-1:0] mask_wdata,
  input  logic         gie,
  output logic [N-1:0] flags,
  output logic [N-1:0] mask,
  output logic [N-1:0] irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      mask  <= '0;
    end else begin
      flags <= (flags & ~(clr | ack)) | set;
      if (mask_wr) mask <= mask_wdata;
    end
  end

  assign irq = flags & mask & {N{gie}};
endmodule

// File: rtl/cc_timer16.sv
module cc_timer16
  import cc_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic [1:0]       mode_sel,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             cmpa_wr,
  input  logic [CNT_W-1:0] cmpa_wdata,
  input  logic             cmpb_wr,
  input  logic [CNT_W-1:0] cmpb_wdata,
  input  logic             cap_wr,
  input  logic [CNT_W-1:0] cap_wdata,
  input  logic             cap_evt,
  input  logic             force_a,
  input  logic             force_b,
  input  logic             mask_wr,
  input  logic [NUM_FLG-1:0] mask_wdata,
  input  logic [NUM_FLG-1:0] flag_clr,
  input  logic             gie,
  input  logic [NUM_FLG-1:0] irq_ack,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cap_o,
  output logic [NUM_FLG-1:0] flags_o,
  output logic [NUM_FLG-1:0] irq_o,
  output logic             match_a_o,
  output logic             match_b_o
);
  tmode_e mode;
  assign mode = tmode_e'(mode_sel);

  logic             cmp_en, roll_evt, top_evt;
  logic [CNT_W-1:0] cap_q;
  logic             cap_is_top;
  logic             cap_take;

  logic [NUM_CMP-1:0]            cmp_wr_v, force_v, hit_v, pulse_v;
  logic [NUM_CMP-1:0][CNT_W-1:0] cmp_wdata_v, cmp_val;
  logic [NUM_FLG-1:0]            flag_set;
  logic [NUM_FLG-1:0]            mask_q;

  assign cmp_wr_v    = {cmpb_wr, cmpa_wr};
  assign cmp_wdata_v = {cmpb_wdata, cmpa_wdata};
  assign force_v     = {force_b, force_a};

  cc_timer_count #(.W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .tick(tick_en), .mode(mode),
    .wr(cnt_wr), .wdata(cnt_wdata), .top_a(cmp_val[0]), .top_cap(cap_q),
    .cnt(cnt_o), .cmp_en(cmp_en), .roll_evt(roll_evt), .top_evt(top_evt)
  );

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
    cc_timer_cmp #(.W(CNT_W)) u_cmp (
      .clk(clk), .rst_n(rst_n), .cmp_en(cmp_en), .cnt(cnt_o),
      .wr(cmp_wr_v[g]), .wdata(cmp_wdata_v[g]), .force_i(force_v[g]),
      .val(cmp_val[g]), .hit(hit_v[g]), .pulse(pulse_v[g])
    );
  end

  assign cap_is_top = (mode == MODE_TOP_CAP);
  assign cap_take   = cap_evt & ~cap_is_top;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cap_q <= '0;
    else if (cap_take) cap_q <= cnt_o;
    else if (cap_wr)   cap_q <= cap_wdata;
  end

  always_comb begin
    flag_set           = '0;
    flag_set[FLG_ROLL] = roll_evt;
    flag_set[FLG_CMPA] = hit_v[0];
    flag_set[FLG_CMPB] = hit_v[1];
    flag_set[FLG_CAP]  = cap_is_top ? top_evt : cap_evt;
  end

  cc_timer_irq #(.N(NUM_FLG)) u_irq (
    .clk(clk), .rst_n(rst_n), .set(flag_set), .clr(flag_clr), .ack(irq_ack),
    .mask_wr(mask_wr), .mask_wdata(mask_wdata), .gie(gie),
    .flags(flags_o), .mask(mask_q), .irq(irq_o)
  );

  assign cap_o     = cap_q;
  assign match_a_o = pulse_v[0];
  assign match_b_o = pulse_v[1];
endmodule

// File: rtl/cc_timer16_chk.sv
module cc_timer16_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick_en,
  input logic [1:0]   mode_sel,
  input logic         cnt_wr,
  input logic         force_a,
  input logic [3:0]   flag_clr,
  input logic         gie,
  input logic [W-1:0] cmpa,
  input logic [W-1:0] cnt_o,
  input logic [3:0]   flags_o,
  input logic [3:0]   irq_o,
  input logic         match_a_o
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  p_cmpa_after_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_o[1]) |-> $past(tick_en && !cnt_wr));

  p_load_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt_wr) && !cnt_wr && tick_en && !force_a) |=> !match_a_o);

  p_force_no_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (force_a && !flags_o[1] && !(tick_en && !cnt_wr && cnt_o == cmpa))
      |=> !flags_o[1]);

  p_top_a_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b01 && tick_en && !cnt_wr && cnt_o == cmpa) |=> cnt_o == '0);

  p_free_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b00 && tick_en && !cnt_wr && cnt_o == MAXV)
      |=> (cnt_o == '0 && flags_o[0]));

  p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !cnt_wr && cnt_o == MAXV && flag_clr[0]) |=> flags_o[0]);

  p_irq_gated_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_o) |-> gie);
endmodule

bind cc_timer16 cc_timer16_chk #(.W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .mode_sel(mode_sel),
  .cnt_wr(cnt_wr), .force_a(force_a), .flag_clr(flag_clr), .gie(gie),
  .cmpa(cmp_val[0]), .cnt_o(cnt_o), .flags_o(flags_o), .irq_o(irq_o),
  .match_a_o(match_a_o)
);

// File: tb/cc_timer16_tb_top.sv
`timescale 1ns/1ps
module cc_timer16_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic tick_en = 0, cnt_wr = 0, cmpa_wr = 0, cmpb_wr = 0, cap_wr = 0, cap_evt = 0;
  logic force_a = 0, force_b = 0, mask_wr = 0, gie = 0;
  logic [1:0]  mode_sel = 0;
  logic [15:0] cnt_wdata = 0, cmpa_wdata = 0, cmpb_wdata = 0, cap_wdata = 0;
  logic [3:0]  mask_wdata = 0, flag_clr = 0, irq_ack = 0;
  logic [15:0] cnt_o, cap_o;
  logic [3:0]  flags_o, irq_o;
  logic        match_a_o, match_b_o;

  cc_timer16 dut_i (.*);

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference
  logic [15:0] m_cnt, m_ca, m_cb, m_cap;
  logic [3:0]  m_flg, m_msk, m_set;
  logic        m_blk, m_ma, m_mb, m_adv, m_top, m_capmode;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_ca = 0; m_cb = 0; m_cap = 0; m_flg = 0; m_msk = 0;
      m_blk = 0; m_ma = 0; m_mb = 0;
    end else begin
      m_adv = tick_en && !cnt_wr;
      m_capmode = (mode_sel == 2'b10);
      m_top = m_adv && ((mode_sel == 2'b01 && m_cnt == m_ca) || (m_capmode && m_cnt == m_cap));
      m_set[0] = m_adv && m_cnt == 16'hFFFF;
      m_set[1] = m_adv && !m_blk && m_cnt == m_ca;
      m_set[2] = m_adv && !m_blk && m_cnt == m_cb;
      m_set[3] = m_capmode ? (m_adv && m_cnt == m_cap) : cap_evt;
      m_ma = m_set[1] || force_a;
      m_mb = m_set[2] || force_b;
      if (!m_capmode && cap_evt) m_cap = m_cnt;
      else if (cap_wr) m_cap = cap_wdata;
      m_flg = (m_flg & ~(flag_clr | irq_ack)) | m_set;
      if (mask_wr) m_msk = mask_wdata;
      if (cmpa_wr) m_ca = cmpa_wdata;
      if (cmpb_wr) m_cb = cmpb_wdata;
      if (cnt_wr) m_cnt = cnt_wdata;
      else if (m_adv) m_cnt = m_top ? 16'h0 : m_cnt + 16'h1;
      m_blk = cnt_wr ? 1'b1 : (tick_en ? 1'b0 : m_blk);
    end
  end

  always begin
    @(posedge clk); #2;
    if (rst_n && !done) begin
      check("R2 count", cnt_o, m_cnt);
      check("R5 flags", flags_o, m_flg);
      check("R12 irq", irq_o, m_flg & m_msk & {4{gie}});
      check("R7 match_a", match_a_o, m_ma);
      check("R7 match_b", match_b_o, m_mb);
      check("R8 capture", cap_o, m_cap);
    end
  end

  task automatic strobes_off();
    cnt_wr = 0; cmpa_wr = 0; cmpb_wr = 0; cap_wr = 0; cap_evt = 0;
    force_a = 0; force_b = 0; mask_wr = 0; flag_clr = 0; irq_ack = 0;
  endtask

  task automatic at_check(); @(posedge clk); #2; endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    at_check();
    check("R1 cnt", cnt_o, 0);
    check("R1 flags", flags_o, 0);
    check("R1 cap", cap_o, 0);
    check("R1 irq", irq_o, 0);
    check("R1 pulse", {match_a_o, match_b_o}, 0);

    // free-running, rollover and compare hits
    @(negedge clk);
    mask_wr = 1; mask_wdata = 4'hF; gie = 1;
    cmpa_wr = 1; cmpa_wdata = 16'h0003; cmpb_wr = 1; cmpb_wdata = 16'hFFFE;
    cnt_wr = 1; cnt_wdata = 16'hFFFD;
    @(negedge clk); strobes_off(); tick_en = 1;
    at_check();                                   // FFFD -> FFFE, blocked
    check("R6 blocked flags", flags_o, 0);
    at_check();                                   // FFFE matches B
    check("R5 flag B", flags_o[2], 1);
    check("R5 pulse B", match_b_o, 1);
    check("R2 count FFFF", cnt_o, 16'hFFFF);
    @(negedge clk); flag_clr = 4'b0001;           // clear during rollover
    at_check();
    check("R3 wrap", cnt_o, 0);
    check("R11 set wins", flags_o[0], 1);
    check("R12 irq roll", irq_o[0], 1);
    @(negedge clk); flag_clr = 0;
    repeat (3) at_check();                        // 0->1->2->3
    at_check();                                   // 3 matches A
    check("R5 flag A", flags_o[1], 1);
    check("R5 pulse A", match_a_o, 1);
    check("R2 count 4", cnt_o, 4);

    // load equal to compare A, then tick: no hit
    @(negedge clk); tick_en = 0; cnt_wr = 1; cnt_wdata = 16'h0003; flag_clr = 4'b0010;
    @(negedge clk); strobes_off(); tick_en = 1;
    at_check();
    check("R6 no flag A", flags_o[1], 0);
    check("R6 no pulse A", match_a_o, 0);

    // gating, acknowledge, write-zero
    @(negedge clk); tick_en = 0; gie = 0;
    at_check();
    check("R12 gie off", irq_o, 0);
    check("R10 flags before", flags_o, 4'b0101);
    @(negedge clk); irq_ack = 4'b0001;
    at_check();
    check("R10 ack", flags_o, 4'b0100);
    @(negedge clk); irq_ack = 0;
    at_check();
    check("R10 zero no effect", flags_o, 4'b0100);
    @(negedge clk); flag_clr = 4'b0100;
    at_check();
    check("R10 w1c", flags_o, 0);

    // restart at compare A
    @(negedge clk); strobes_off(); gie = 1; mode_sel = 2'b01;
    cmpa_wr = 1; cmpa_wdata = 2; cnt_wr = 1; cnt_wdata = 0;
    @(negedge clk); strobes_off(); tick_en = 1;
    at_check(); at_check(); at_check();
    check("R4 restart", cnt_o, 0);

    // force strobe
    @(negedge clk); flag_clr = 4'hF; tick_en = 0;
    @(negedge clk); strobes_off(); tick_en = 1; force_a = 1;
    at_check();
    check("R7 force pulse", match_a_o, 1);
    check("R7 force no flag", flags_o[1], 0);
    check("R7 force no clear", cnt_o, 1);

    // capture beats write
    @(negedge clk); strobes_off(); tick_en = 0; mode_sel = 2'b00;
    cap_evt = 1; cap_wr = 1; cap_wdata = 16'h1234;
    at_check();
    check("R8 captured", cap_o, 1);
    check("R8 cap flag", flags_o[3], 1);

    // capture register as period
    @(negedge clk); strobes_off(); flag_clr = 4'hF; mode_sel = 2'b10;
    cap_wr = 1; cap_wdata = 2; cnt_wr = 1; cnt_wdata = 0;
    @(negedge clk); strobes_off(); tick_en = 1; cap_evt = 1;
    at_check();
    check("R9 evt ignored", cap_o, 2);
    at_check();
    check("R9 no early flag", flags_o[3], 0);
    at_check();
    check("R9 restart", cnt_o, 0);
    check("R9 top flag", flags_o[3], 1);

    // randomized collisions
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      strobes_off();
      tick_en   = ($urandom_range(0, 9) < 7);
      if ($urandom_range(0, 99) < 3) mode_sel = 2'($urandom_range(0, 3));
      cnt_wr    = ($urandom_range(0, 29) == 0);
      cnt_wdata = ($urandom_range(0, 1) == 1) ? 16'(16'hFFF8 + $urandom_range(0, 7)) : 16'($urandom_range(0, 12));
      cmpa_wr   = ($urandom_range(0, 49) == 0); cmpa_wdata = 16'($urandom_range(0, 12));
      cmpb_wr   = ($urandom_range(0, 49) == 0); cmpb_wdata = 16'($urandom_range(0, 12));
      cap_wr    = ($urandom_range(0, 49) == 0); cap_wdata  = 16'($urandom_range(1, 12));
      cap_evt   = ($urandom_range(0, 39) == 0);
      force_a   = ($urandom_range(0, 39) == 0);
      force_b   = ($urandom_range(0, 39) == 0);
      mask_wr   = ($urandom_range(0, 29) == 0); mask_wdata = 4'($urandom_range(0, 15));
      flag_clr  = ($urandom_range(0, 7) == 0) ? 4'($urandom_range(0, 15)) : 4'h0;
      irq_ack   = ($urandom_range(0, 7) == 0) ? 4'($urandom_range(0, 15)) : 4'h0;
      if ($urandom_range(0, 19) == 0) gie = ~gie;
    end
    @(negedge clk); strobes_off();
    at_check();
    finish_run();
  end
endmodule